// File: doc/BRIEF.md
# Direct-Mapped Branch Target Buffer

This block predicts the next fetch address from the fetch address alone, before the instruction has been decoded. It keeps a direct-mapped table of 2^IDX_W slots. Each slot holds a valid flag, the full address of a control-transfer instruction and the next address that instruction was last found to go to. A lookup that finds its own full address in the selected slot returns the stored next address and raises a hit flag. Any other lookup returns the sequential address, the fetch address plus 4.

The execute side writes the table through a single update port. It writes only for branches and jumps, and in practice only when a prediction turned out wrong. The update carries the branch address and the correct next address: the computed target for a taken branch, or the branch address plus 4 for one that was not taken. The lookup path is purely combinational, so a fetch stage can use the result in the same cycle. An update lands at the next rising clock edge.

The block has no sequencing of its own. Its behaviour has two named phases per slot: EMPTY, entered on reset, and FILLED, entered on the edge that writes the slot. A FILLED slot moves to FILLED with new contents on every later write to the same index. Only reset returns a slot to EMPTY.

Top module: `btb_predictor`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, every slot is EMPTY: any lookup gives `pred_hit` = 0 and `pred_next` = `fetch_pc` + 4. A reset issued later discards all earlier writes in the same way.
- R2: The slot is selected by address bits [IDX_W+1:2], which are `fetch_pc` bits [5:2] for a lookup and `upd_pc` bits [5:2] for an update at the default IDX_W = 4. Writes to the 16 different slot numbers all coexist.
- R3: A lookup hits when the selected slot is FILLED and its stored address equals all ADDR_W bits of `fetch_pc`. On a hit, `pred_hit` = 1 and `pred_next` equals the stored next address.
- R4: On a miss, `pred_hit` = 0 and `pred_next` = `fetch_pc` + 4, taken modulo 2^ADDR_W, so 0xFFFFFFFC gives 0x00000000.
- R5: When `upd_en` is 1 at a rising edge, the slot chosen by `upd_pc` takes `upd_pc` as its address and `upd_next` as its next address. Both replace whatever the slot held before, including an entry for a different address.
- R6: When `upd_en` is 0 at a rising edge, the table is unchanged, whatever values `upd_pc` and `upd_next` carry.
- R7: A lookup whose address shares a slot number with a stored entry but differs from it in any other bit misses. This covers the upper bits and address bits [1:0].
- R8: The lookup is combinational. In the cycle that carries an update, a lookup of the address being updated still shows the table contents from before the update. The new contents appear from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; updates take effect on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; empties every slot |
| fetch_pc | input | ADDR_W | Address being fetched |
| pred_next | output | ADDR_W | Predicted next fetch address |
| pred_hit | output | 1 | 1 when the prediction came from a stored entry |
| upd_en | input | 1 | Write request for one slot |
| upd_pc | input | ADDR_W | Address of the control-transfer instruction being recorded |
| upd_next | input | ADDR_W | Correct next address for that instruction |

## Verification
Directed cases come first. A full sweep of all 16 slot numbers checks that every slot is independent. Further cases check aliases that share a slot but differ in the upper bits or in bits [1:0], which separates a full-address compare from a partial tag compare. Other cases cover a lookup and an update of the same address in one cycle, which tells a registered write apart from a write-through path, an eviction by an aliasing address, a disabled write that carries live data, wrap-around at the top of the address space, and a mid-run reset. A seeded random phase then draws addresses from a small pool made of two upper regions crossed with all slot numbers, with an occasional misaligned address. This makes hits, alias misses and overwrites frequent, and every lookup is compared against a reference table kept in the bench.

// File: rtl/btb_pkg.sv
package btb_pkg;
    // Instructions are 4 bytes wide, so the two lowest address bits never select a slot.
    localparam int unsigned INSTR_BYTES = 4;
    localparam int unsigned ALIGN_SHIFT = 2;

    // Slot life-cycle phases, named in the brief.
    typedef enum logic {
        SLOT_EMPTY  = 1'b0,
        SLOT_FILLED = 1'b1
    } slot_state_e;
endpackage

// File: rtl/btb_index.sv
module btb_index #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned IDX_W  = 4
) (
    input  logic [ADDR_W-1:0] pc,
    output logic [IDX_W-1:0]  idx
);
    logic [ADDR_W-1:0] shifted;

    assign shifted = pc >> btb_pkg::ALIGN_SHIFT;
    assign idx     = shifted[IDX_W-1:0];

    // The bits above the slot number matter only to the tag compare.
    logic unused_hi;
    assign unused_hi = ^shifted[ADDR_W-1:IDX_W];
endmodule

// File: rtl/btb_entry_array.sv
module btb_entry_array #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned IDX_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [ADDR_W-1:0]   wr_tag,
    input  logic [ADDR_W-1:0]   wr_tgt,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic                rd_valid,
    output logic [ADDR_W-1:0]   rd_tag,
    output logic [ADDR_W-1:0]   rd_tgt
);
    import btb_pkg::*;

    localparam int unsigned DEPTH = 1 << IDX_W;

    slot_state_e       state_q [DEPTH];
    logic [ADDR_W-1:0] tag_q   [DEPTH];
    logic [ADDR_W-1:0] tgt_q   [DEPTH];
    logic [DEPTH-1:0]  sel;

    always_comb begin
        sel = '0;
        sel[wr_idx] = wr_en;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        // State register: EMPTY on reset; any write leaves the slot FILLED.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                state_q[g] <= SLOT_EMPTY;
            end else begin
                unique case (state_q[g])
                    SLOT_EMPTY:  if (sel[g]) state_q[g] <= SLOT_FILLED;
                    SLOT_FILLED: state_q[g] <= SLOT_FILLED;
                    default:     state_q[g] <= SLOT_EMPTY;
                endcase
            end
        end

        // Payload: address and next address are replaced together.
        always_ff @(posedge clk) begin
            if (sel[g]) begin
                tag_q[g] <= wr_tag;
                tgt_q[g] <= wr_tgt;
            end
        end
    end

    assign rd_valid = (state_q[rd_idx] == SLOT_FILLED);
    assign rd_tag   = tag_q[rd_idx];
    assign rd_tgt   = tgt_q[rd_idx];
endmodule

// File: rtl/btb_lookup.sv
module btb_lookup #(
    parameter int unsigned ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic              slot_valid,
    input  logic [ADDR_W-1:0] slot_tag,
    input  logic [ADDR_W-1:0] slot_tgt,
    output logic              hit,
    output logic [ADDR_W-1:0] next_pc
);
    logic [ADDR_W-1:0] seq_pc;

    assign seq_pc = pc + ADDR_W'(btb_pkg::INSTR_BYTES);

    always_comb begin
        hit     = slot_valid && (slot_tag == pc);
        next_pc = hit ? slot_tgt : seq_pc;
    end
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] fetch_pc,
    output logic [ADDR_W-1:0] pred_next,
    output logic              pred_hit,
    input  logic              upd_en,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic [ADDR_W-1:0] upd_next
);
    logic [IDX_W-1:0]  rd_idx;
    logic [IDX_W-1:0]  wr_idx;
    logic              slot_valid;
    logic [ADDR_W-1:0] slot_tag;
    logic [ADDR_W-1:0] slot_tgt;

    btb_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_rd_index (
        .pc  (fetch_pc),
        .idx (rd_idx)
    );

    btb_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_wr_index (
        .pc  (upd_pc),
        .idx (wr_idx)
    );

    btb_entry_array #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (upd_en),
        .wr_idx   (wr_idx),
        .wr_tag   (upd_pc),
        .wr_tgt   (upd_next),
        .rd_idx   (rd_idx),
        .rd_valid (slot_valid),
        .rd_tag   (slot_tag),
        .rd_tgt   (slot_tgt)
    );

    btb_lookup #(.ADDR_W(ADDR_W)) u_lookup (
        .pc         (fetch_pc),
        .slot_valid (slot_valid),
        .slot_tag   (slot_tag),
        .slot_tgt   (slot_tgt),
        .hit        (pred_hit),
        .next_pc    (pred_next)
    );
endmodule

// File: rtl/btb_predictor_chk.sv
module btb_predictor_chk #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] fetch_pc,
    input logic [ADDR_W-1:0] pred_next,
    input logic              pred_hit,
    input logic              upd_en,
    input logic [ADDR_W-1:0] upd_pc,
    input logic [ADDR_W-1:0] upd_next
);
    // R1
    empty_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !pred_hit);

    // R4
    miss_sequential_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_hit |-> pred_next == fetch_pc + ADDR_W'(4));

    // R5
    write_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(upd_en) && fetch_pc == $past(upd_pc))
            |-> (pred_hit && pred_next == $past(upd_next)));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(upd_en) && $stable(fetch_pc))
            |-> ($stable(pred_hit) && $stable(pred_next)));
endmodule

bind btb_predictor btb_predictor_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fetch_pc  (fetch_pc),
    .pred_next (pred_next),
    .pred_hit  (pred_hit),
    .upd_en    (upd_en),
    .upd_pc    (upd_pc),
    .upd_next  (upd_next)
);

// File: tb/tb_btb_predictor.sv
module tb_btb_predictor;
    localparam int AW    = 32;
    localparam int IW    = 4;
    localparam int DEPTH = 1 << IW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] fetch_pc = '0;
    logic [AW-1:0] pred_next;
    logic          pred_hit;
    logic          upd_en = 1'b0;
    logic [AW-1:0] upd_pc = '0;
    logic [AW-1:0] upd_next = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic          m_valid [DEPTH];
    logic [AW-1:0] m_tag   [DEPTH];
    logic [AW-1:0] m_tgt   [DEPTH];

    always #2 clk = ~clk;

    btb_predictor #(.ADDR_W(AW), .IDX_W(IW)) dut (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .pred_next(pred_next),
        .pred_hit(pred_hit), .upd_en(upd_en), .upd_pc(upd_pc), .upd_next(upd_next)
    );

    function automatic int slot_of(logic [AW-1:0] a);
        return int'(a[IW+1:2]);
    endfunction

    function automatic logic exp_hit(logic [AW-1:0] a);
        return m_valid[slot_of(a)] && (m_tag[slot_of(a)] == a);
    endfunction

    function automatic logic [AW-1:0] exp_next(logic [AW-1:0] a);
        return exp_hit(a) ? m_tgt[slot_of(a)] : a + 32'd4;
    endfunction

    task automatic model_clear();
        for (int i = 0; i < DEPTH; i++) m_valid[i] = 1'b0;
    endtask

    task automatic check(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: pc=%h actual=%h expected=%h", req, fetch_pc, act, exp);
        end
    endtask

    // Drive one cycle: set inputs after the falling edge, check the
    // combinational lookup, then let the rising edge apply any write.
    task automatic step(string req, logic [AW-1:0] pc, logic en,
                        logic [AW-1:0] wpc, logic [AW-1:0] wnx);
        @(negedge clk);
        fetch_pc = pc; upd_en = en; upd_pc = wpc; upd_next = wnx;
        #1;
        check(req, {31'd0, pred_hit}, {31'd0, exp_hit(pc)});
        check(req, pred_next, exp_next(pc));
        @(posedge clk);
        if (en) begin
            m_valid[slot_of(wpc)] = 1'b1;
            m_tag[slot_of(wpc)]   = wpc;
            m_tgt[slot_of(wpc)]   = wnx;
        end
    endtask

    task automatic look(string req, logic [AW-1:0] pc);
        step(req, pc, 1'b0, 32'hDEAD_BEE0, 32'h1234_5678);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; upd_en = 1'b0;
        model_clear();
        #1;
        fetch_pc = 32'h0000_0100;
        #1;
        check("R1", {31'd0, pred_hit}, 32'd0);
        check("R1", pred_next, 32'h0000_0104);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2718);
        model_clear();
        do_reset();

        // R1: every slot empty after reset
        for (int i = 0; i < DEPTH; i++) look("R1", 32'h0000_4000 | (i << 2));

        // R2: one write per slot number, all coexist
        for (int i = 0; i < DEPTH; i++)
            step("R2", 32'h0, 1'b1, 32'h0000_8000 | (i << 2), 32'h0009_0000 + (i << 4));
        for (int i = 0; i < DEPTH; i++) look("R2", 32'h0000_8000 | (i << 2));

        // R3 / R5: write then hit
        step("R5", 32'h0, 1'b1, 32'h0000_0100, 32'h0000_2000);
        look("R3", 32'h0000_0100);
        // R7: aliases in upper bits and in bits [1:0]
        look("R7", 32'h0000_0140);
        look("R7", 32'h8000_0100);
        look("R7", 32'h0000_0101);
        // R8: same-cycle lookup sees the old target, then the new one
        step("R8", 32'h0000_0100, 1'b1, 32'h0000_0100, 32'h0000_3000);
        look("R8", 32'h0000_0100);
        // R5: alias eviction
        step("R5", 32'h0, 1'b1, 32'h0000_0140, 32'h0000_0500);
        look("R5", 32'h0000_0100);
        look("R5", 32'h0000_0140);
        // R6: disabled write with live data changes nothing
        step("R6", 32'h0000_0140, 1'b0, 32'h0000_0140, 32'hFFFF_0000);
        look("R6", 32'h0000_0140);
        step("R6", 32'h0, 1'b0, 32'h0000_0180, 32'h0000_0777);
        look("R6", 32'h0000_0180);
        // R4: wrap-around
        look("R4", 32'hFFFF_FFFC);

        // Constrained random mix
        for (int n = 0; n < 600; n++) begin
            logic [AW-1:0] a, w, t;
            logic e;
            a = ($urandom() & 1) ? 32'h0001_0000 : 32'h0000_0000;
            a = a | (($urandom() % DEPTH) << 2) | ((($urandom() % 8) == 0) ? 32'd2 : 32'd0);
            w = (($urandom() & 1) ? 32'h0001_0000 : 32'h0000_0000) | (($urandom() % DEPTH) << 2);
            t = $urandom() & 32'hFFFF_FFFC;
            e = ($urandom() % 3) == 0;
            if (($urandom() % 4) == 0) a = w;
            step("R3", a, e, w, t);
        end

        // R1: mid-run reset discards earlier writes
        step("R5", 32'h0, 1'b1, 32'h0000_0100, 32'h0000_2000);
        do_reset();
        look("R1", 32'h0000_0100);
        look("R1", 32'h0000_8004);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule